// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block holds the two control registers that steer an on-chip flash array and decides, every clock, whether program, erase and verify operations may proceed. A 4-bit mode register selects the operation. A per-block enable register selects which flash blocks an erase touches. The block turns these registers into permit signals for the flash sequencer. It clears them, freezes them or blocks them according to the protection inputs.

There are three kinds of protection, and each has its own effect. A hard reset clears both registers and the sticky error flag. A hard reset is a qualified reset-pin pulse, a watchdog overflow reset or hardware standby. A low write-enable pin or software standby clears the registers but leaves the error flag alone. An operation error during a program or erase aborts that operation with a one-cycle pulse. It sets the error flag, after which the registers are frozen. Verify stays allowed while the registers are frozen.

The external reset pin passes through a low-time qualifier. Only a pulse held low for the full minimum count acts as a reset. Shorter glitches are ignored.

Top module: `flash_guard`

## Requirements
- R1: While `we_pin` is 0, `prog_ok`, `erase_ok` and `verify_ok` are 0 in the same cycle. On each edge that samples `we_pin` at 0, `mode_q` and `blk_q` become 0, and register writes are ignored.
- R2: An edge that samples `wdt_rst`, `hw_stby` or `sleep_req` at 1 clears `mode_q` and `blk_q`. All permits are 0 while any of these inputs is 1.
- R3: If `op_err` is 1 at an edge where `prog_ok` or `erase_ok` is 1, that edge sets `err_flag`, raises `abort_pulse` for exactly one cycle and keeps `mode_q` and `blk_q` unchanged.
- R4: While `err_flag` is 1, `prog_ok`, `erase_ok` and `blk_sel` are 0. `verify_ok` is 1 when mode bit 2 or bit 3 is set. Writes to both registers are ignored.
- R5: Only a qualified reset-pin pulse, `wdt_rst` or `hw_stby` clears `err_flag`. A low `we_pin` and `sleep_req` leave it set.
- R6: `ext_rst_n` acts as a reset only on the edge that samples its MIN_LOW-th consecutive low value (20 by default), and on later edges while it stays low. A shorter low pulse changes nothing.
- R7: `blk_sel` equals `blk_q` when `erase_ok` is 1 and is 0 otherwise.
- R8: `op_err` while neither `prog_ok` nor `erase_ok` is 1 has no effect. `err_flag` and `abort_pulse` stay 0.
- R9: With no protection active, a write with `mode_wr` or `blk_wr` loads the register on the next edge. Mode bit 0 gives `prog_ok`, bit 1 gives `erase_ok`, and bit 2 (program-verify) or bit 3 (erase-verify) gives `verify_ok`.
- R10: Priority is hard reset (qualified pin reset, watchdog, hardware standby) first, then write-enable low or software standby, then error freeze, then normal operation. For example, `op_err` in a cycle with `we_pin` at 0 produces no abort and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| we_pin | input | 1 | Flash write-enable pin, 0 = protected |
| ext_rst_n | input | 1 | External reset pin, active low, qualified by low time |
| wdt_rst | input | 1 | Watchdog overflow reset |
| sleep_req | input | 1 | Software standby indication |
| hw_stby | input | 1 | Hardware standby indication |
| op_err | input | 1 | Operation-error detect strobe |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 4 | Mode write data: bit0 program, bit1 erase, bit2 program-verify, bit3 erase-verify |
| blk_wr | input | 1 | Write strobe for the block-enable register |
| blk_wdata | input | NBLK | Block-enable write data |
| prog_ok | output | 1 | Program permitted |
| erase_ok | output | 1 | Erase permitted |
| verify_ok | output | 1 | Verify permitted |
| blk_sel | output | NBLK | Effective block selection for erase |
| abort_pulse | output | 1 | One-cycle abort of a running program/erase |
| err_flag | output | 1 | Sticky operation-error flag |
| mode_q | output | 4 | Current mode register |
| blk_q | output | NBLK | Current block-enable register |

## Verification
Each protection cause is tried against a loaded register set, so the bench can tell a clearing cause from a freezing one. An error strobe is applied three ways: during a program, during a verify-only mode, and in the same cycle as a low write-enable. Together these separate a genuine abort, an ignored strobe and a priority override. The error flag is then attacked by every input that should leave it set, and then by those that should clear it. Reset-pin pulses of 19 and 20 low cycles bracket the qualification threshold.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int MODE_W = 4;
  localparam int PGM_BIT = 0;
  localparam int ERS_BIT = 1;
  localparam int PV_BIT  = 2;
  localparam int EV_BIT  = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_FREEZE = 2'd1,
    CAUSE_CLEAR  = 2'd2,
    CAUSE_HARD   = 2'd3
  } cause_e;
endpackage

// File: rtl/fg_rst_filter.sv
module fg_rst_filter #(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic qual_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CAP = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || pin_n) begin
      low_cnt <= '0;
    end else if (low_cnt != CAP) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign qual_o = !pin_n && (low_cnt == CAP);

  // R6
  qual_needs_history_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_o && (MIN_LOW > 1)) |-> $past(!pin_n));

  // R6
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= CAP);
endmodule

// File: rtl/fg_arbiter.sv
module fg_arbiter
  import flash_guard_pkg::*;
(
  input  logic   pin_rst_qual,
  input  logic   wdt_rst,
  input  logic   hw_stby,
  input  logic   we_pin,
  input  logic   sleep_req,
  input  logic   err_q,
  output cause_e cause_o
);
  logic hard_c, clear_c;

  assign hard_c  = pin_rst_qual | wdt_rst | hw_stby;
  assign clear_c = !we_pin | sleep_req;

  always_comb begin
    if (hard_c)       cause_o = CAUSE_HARD;
    else if (clear_c) cause_o = CAUSE_CLEAR;
    else if (err_q)   cause_o = CAUSE_FREEZE;
    else              cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/fg_regs.sv
module fg_regs
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cause_e            cause,
  input  logic              busy,
  input  logic              op_err,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              blk_wr,
  input  logic [NBLK-1:0]   blk_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [NBLK-1:0]   blk_q,
  output logic              err_q,
  output logic              abort_q
);
  logic hit_err;
  assign hit_err = op_err && busy;

  always_ff @(posedge clk) begin
    if (rst || cause == CAUSE_HARD) begin
      mode_q  <= '0;
      blk_q   <= '0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      case (cause)
        CAUSE_CLEAR: begin
          mode_q <= '0;
          blk_q  <= '0;
        end
        CAUSE_FREEZE: ;
        default: begin
          if (hit_err) begin
            err_q   <= 1'b1;
            abort_q <= 1'b1;
          end else begin
            if (mode_wr) mode_q <= mode_wdata;
            if (blk_wr)  blk_q  <= blk_wdata;
          end
        end
      endcase
    end
  end

  // R3
  abort_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q);

  // R3
  abort_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> err_q);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && cause != CAUSE_HARD) |=> err_q);

  // R1
  clear_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (cause == CAUSE_CLEAR) |=> (mode_q == '0 && blk_q == '0));

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cause == CAUSE_FREEZE) |=> ($stable(mode_q) && $stable(blk_q)));
endmodule

// File: rtl/fg_permit.sv
module fg_permit
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  cause_e            cause,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [NBLK-1:0]   blk_q,
  output logic              prog_ok,
  output logic              erase_ok,
  output logic              verify_ok,
  output logic [NBLK-1:0]   blk_sel
);
  logic open_c, verify_c;

  assign open_c    = (cause == CAUSE_NONE);
  assign verify_c  = (cause == CAUSE_NONE) || (cause == CAUSE_FREEZE);
  assign prog_ok   = open_c && mode_q[PGM_BIT];
  assign erase_ok  = open_c && mode_q[ERS_BIT];
  assign verify_ok = verify_c && (mode_q[PV_BIT] || mode_q[EV_BIT]);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_sel[b] = erase_ok && blk_q[b];
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NBLK    = 8,
  parameter int MIN_LOW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_pin,
  input  logic              ext_rst_n,
  input  logic              wdt_rst,
  input  logic              sleep_req,
  input  logic              hw_stby,
  input  logic              op_err,
  input  logic              mode_wr,
  input  logic [3:0]        mode_wdata,
  input  logic              blk_wr,
  input  logic [NBLK-1:0]   blk_wdata,
  output logic              prog_ok,
  output logic              erase_ok,
  output logic              verify_ok,
  output logic [NBLK-1:0]   blk_sel,
  output logic              abort_pulse,
  output logic              err_flag,
  output logic [3:0]        mode_q,
  output logic [NBLK-1:0]   blk_q
);
  logic   pin_qual;
  cause_e cause;

  fg_rst_filter #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk(clk), .rst(rst), .pin_n(ext_rst_n), .qual_o(pin_qual)
  );

  fg_arbiter u_arb (
    .pin_rst_qual(pin_qual), .wdt_rst(wdt_rst), .hw_stby(hw_stby),
    .we_pin(we_pin), .sleep_req(sleep_req), .err_q(err_flag),
    .cause_o(cause)
  );

  fg_regs #(.NBLK(NBLK)) u_regs (
    .clk(clk), .rst(rst), .cause(cause), .busy(prog_ok | erase_ok),
    .op_err(op_err), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .mode_q(mode_q),
    .blk_q(blk_q), .err_q(err_flag), .abort_q(abort_pulse)
  );

  fg_permit #(.NBLK(NBLK)) u_perm (
    .cause(cause), .mode_q(mode_q), .blk_q(blk_q), .prog_ok(prog_ok),
    .erase_ok(erase_ok), .verify_ok(verify_ok), .blk_sel(blk_sel)
  );

  // R1
  pin_low_block_chk: assert property (@(posedge clk) disable iff (rst)
    !we_pin |-> (!prog_ok && !erase_ok && !verify_ok));

  // R2
  wdt_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> (mode_q == '0 && blk_q == '0 && !err_flag));

  // R4
  err_blocks_pe_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (!prog_ok && !erase_ok && blk_sel == '0));

  // R8
  idle_err_chk: assert property (@(posedge clk) disable iff (rst)
    (op_err && !prog_ok && !erase_ok) |=> !abort_pulse);
endmodule

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, we_pin, ext_rst_n, wdt_rst, sleep_req, hw_stby, op_err;
  logic mode_wr, blk_wr;
  logic [3:0] mode_wdata;
  logic [NB-1:0] blk_wdata;
  logic prog_ok, erase_ok, verify_ok, abort_pulse, err_flag;
  logic [NB-1:0] blk_sel, blk_q;
  logic [3:0] mode_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  flash_guard #(.NBLK(NB), .MIN_LOW(20)) dut_i (
    .clk(clk), .rst(rst), .we_pin(we_pin), .ext_rst_n(ext_rst_n),
    .wdt_rst(wdt_rst), .sleep_req(sleep_req), .hw_stby(hw_stby),
    .op_err(op_err), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .prog_ok(prog_ok),
    .erase_ok(erase_ok), .verify_ok(verify_ok), .blk_sel(blk_sel),
    .abort_pulse(abort_pulse), .err_flag(err_flag), .mode_q(mode_q),
    .blk_q(blk_q)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [3:0] v);
    mode_wdata = v; mode_wr = 1'b1; step(); mode_wr = 1'b0;
  endtask

  task automatic wr_blk(input logic [NB-1:0] v);
    blk_wdata = v; blk_wr = 1'b1; step(); blk_wr = 1'b0;
  endtask

  task automatic make_err();
    wr_mode(4'b0101);
    op_err = 1'b1; step(); op_err = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset mode_q", mode_q, 0);
    chk("R9 reset blk_q", blk_q, 0);
    chk("R5 reset err_flag", err_flag, 0);
    chk("R3 reset abort", abort_pulse, 0);
  endtask

  task automatic t_normal();
    wr_blk(8'hA5);
    wr_mode(4'b0001);
    chk("R9 blk load", blk_q, 8'hA5);
    chk("R9 prog_ok from bit0", prog_ok, 1);
    chk("R9 erase_ok off", erase_ok, 0);
    chk("R7 blk_sel gated without erase", blk_sel, 0);
    wr_mode(4'b0010);
    chk("R9 erase_ok from bit1", erase_ok, 1);
    chk("R7 blk_sel follows blk_q", blk_sel, 8'hA5);
    wr_mode(4'b1000);
    chk("R9 verify_ok from bit3", verify_ok, 1);
    chk("R9 prog_ok off", prog_ok, 0);
  endtask

  task automatic t_pin_low();
    wr_mode(4'b0111);
    we_pin = 1'b0; #0;
    chk("R1 permits low same cycle", {prog_ok, erase_ok, verify_ok}, 0);
    step();
    chk("R1 mode cleared", mode_q, 0);
    chk("R1 blk cleared", blk_q, 0);
    wr_mode(4'b0001);
    chk("R1 write ignored", mode_q, 0);
    we_pin = 1'b1;
  endtask

  task automatic t_standby();
    wr_blk(8'h3C);
    wr_mode(4'b0011);
    sleep_req = 1'b1; #0;
    chk("R2 standby permits low", {prog_ok, erase_ok}, 0);
    step(); sleep_req = 1'b0;
    chk("R2 standby clears mode", mode_q, 0);
    chk("R2 standby clears blk", blk_q, 0);
    wr_mode(4'b0011);
    wdt_rst = 1'b1; step(); wdt_rst = 1'b0;
    chk("R2 watchdog clears mode", mode_q, 0);
  endtask

  task automatic t_error();
    wr_blk(8'h0F);
    make_err();
    chk("R3 err set", err_flag, 1);
    chk("R3 abort high", abort_pulse, 1);
    chk("R3 mode kept", mode_q, 4'b0101);
    chk("R3 blk kept", blk_q, 8'h0F);
    chk("R4 prog blocked", prog_ok, 0);
    chk("R4 verify still allowed", verify_ok, 1);
    step();
    chk("R3 abort one cycle", abort_pulse, 0);
    wr_mode(4'b0010);
    chk("R4 write ignored under error", mode_q, 4'b0101);
    wr_blk(8'hFF);
    chk("R4 blk write ignored", blk_q, 8'h0F);
  endtask

  task automatic t_err_clear();
    we_pin = 1'b0; step(); we_pin = 1'b1;
    chk("R5 pin low keeps err", err_flag, 1);
    chk("R10 pin low clears regs under err", mode_q, 0);
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R5 standby keeps err", err_flag, 1);
    ext_rst_n = 1'b0;
    repeat (19) step();
    ext_rst_n = 1'b1; step();
    chk("R6 19-cycle pulse ignored", err_flag, 1);
    ext_rst_n = 1'b0;
    repeat (19) step();
    chk("R6 not yet at 19th low", err_flag, 1);
    step();
    chk("R6 qualified at 20th low", err_flag, 0);
    ext_rst_n = 1'b1; step();
    make_err();
    chk("R3 err re-set", err_flag, 1);
    hw_stby = 1'b1; step(); hw_stby = 1'b0;
    chk("R5 hw standby clears err", err_flag, 0);
    make_err();
    wdt_rst = 1'b1; step(); wdt_rst = 1'b0;
    chk("R5 watchdog clears err", err_flag, 0);
  endtask

  task automatic t_idle_err();
    wr_mode(4'b0100);
    op_err = 1'b1; step(); op_err = 1'b0;
    chk("R8 idle error no flag", err_flag, 0);
    chk("R8 idle error no abort", abort_pulse, 0);
    chk("R8 mode unchanged", mode_q, 4'b0100);
  endtask

  task automatic t_priority();
    wr_mode(4'b0001);
    we_pin = 1'b0; op_err = 1'b1; step(); op_err = 1'b0; we_pin = 1'b1;
    chk("R10 pin low beats error: abort", abort_pulse, 0);
    chk("R10 pin low beats error: flag", err_flag, 0);
    chk("R10 pin low clears mode", mode_q, 0);
    make_err();
    we_pin = 1'b0; wdt_rst = 1'b1; step(); wdt_rst = 1'b0; we_pin = 1'b1;
    chk("R10 hard reset beats pin low", err_flag, 0);
  endtask

  initial begin
    rst = 1'b1; we_pin = 1'b1; ext_rst_n = 1'b1; wdt_rst = 1'b0;
    sleep_req = 1'b0; hw_stby = 1'b0; op_err = 1'b0;
    mode_wr = 1'b0; blk_wr = 1'b0; mode_wdata = '0; blk_wdata = '0;
    step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_normal();
    t_pin_low();
    t_standby();
    t_error();
    t_err_clear();
    t_idle_err();
    t_priority();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule